// File: doc/BRIEF.md
# LIN Bus Pulse Timer with Receive Gate

This block times low pulses on a single-wire LIN-style serial bus. A prescaled 16-bit counter starts on each falling edge of the bus line and stops on the next rising edge, so the value it holds afterwards is the width of the low pulse in prescaler ticks. Three sticky flags come from this counter: end of pulse (rising edge), a match against a programmed compare value, and saturation at the counter's maximum. Each flag has its own disable bit. The interrupt output is the OR of the flags whose disable bit is clear. Software uses the pulse width to tell a 0, a 1 and a sync pulse apart. When the controller drives the bus, the compare match tells it when to release the line.

A break field is a low pulse that reaches a programmable tick threshold. The sync byte that follows it is 0x55, which appears on the wire as five equal one-bit low pulses. After a break, the block looks for those five pulses. With gating enabled, the receive line to the companion UART is held high until both the break and the sync byte have been seen. After that the live bus level passes straight through. A test mode connects a general-purpose input pin to the transceiver transmit line and copies the transceiver receive line to a general-purpose output pin, bypassing the UART.

Top module: `lin_pulse_timer`

## Requirements
- R1: After reset, the control register (address 0) and status (address 1) read 0, the timer (address 2) reads 0, the break threshold (address 3) reads 52, irq is 0 and uart_rxd follows bus_rx.
- R2: A low pulse on bus_rx lasting L clock cycles leaves the timer reading min(floor(L/PRESCALE), 2^TIMER_W-1). The value holds until the next falling edge.
- R3: At the end of each low pulse, status bit 0 is set while control bit 0 (rising-edge disable) is 0. While that bit is 1 the flag is not set, but the timer still stops on the rising edge and the compare flag still works.
- R4: Writing address 2 loads the compare value. Status bit 1 is set when the running timer steps to a non-zero compare value.
- R5: When the timer reaches its maximum value it saturates there rather than wrapping, and status bit 2 is set.
- R6: irq is 1 exactly when some status bit k (k = 0, 1, 2) is set and control bit k (0 = rising edge, 1 = compare, 2 = overflow disable) is 0.
- R7: Writing 1 to status bits 0 to 2 clears them and writing 0 leaves them unchanged. A set event in the same cycle wins over the clear.
- R8: With control bit 4 (gate) at 1, uart_rxd stays 1 until two things have happened: a pulse of at least the threshold ticks, then five low pulses each within a quarter of the first one's width. Status bit 3 then reads 1 and uart_rxd follows bus_rx. Writing the gate bit from 0 to 1 restarts the search.
- R9: A pulse that does not match the first sync pulse's width abandons the search. A new break closes the gate again and restarts the sync search.
- R10: With control bit 3 (test) at 1, bus_tx equals test_tx_in and test_rx_out equals bus_rx. With it at 0, bus_tx equals uart_txd and test_rx_out is 1.
- R11: The control register is read/write and only bits 4:0 are stored. The bits above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| bus_rx | input | 1 | Receive line from the transceiver |
| bus_tx | output | 1 | Transmit line to the transceiver |
| uart_txd | input | 1 | Transmit data from the UART |
| uart_rxd | output | 1 | Receive data to the UART, gated |
| test_tx_in | input | 1 | Test pin driving the transmit line |
| test_rx_out | output | 1 | Test pin mirroring the receive line |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the locked gate. Getting there needs a full break followed by five sync pulses whose widths land within tolerance after the synchronizer and prescaler. The bench therefore drives whole bit-accurate frames, each a break, a delimiter and a 0x55 byte, at a fixed bit time. It checks that uart_rxd stays high in the middle of the sync byte and follows the bus only afterwards. A variant frame with one stretched low bit drives the mismatch path, and a second break after lock shows the gate closing again. Overflow is reached by building the bench with a narrower timer and holding the bus low for longer than its range.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 2'd0,
        A_STAT  = 2'd1,
        A_TIMER = 2'd2,
        A_BRK   = 2'd3
    } reg_addr_e;

    // control register, bit 0 at the bottom
    typedef struct packed {
        logic gate_en;    // 4
        logic test_mode;  // 3
        logic dis_err;    // 2
        logic dis_cmp;    // 1
        logic dis_edge;   // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam int FL_EDGE = 0;
    localparam int FL_CMP  = 1;
    localparam int FL_ERR  = 2;
    localparam int ST_SYNC = 3;
    localparam int FLAG_N  = 3;

    // timer events, packed in flag bit order
    typedef struct packed {
        logic overflow;
        logic match;
        logic rise;
    } tmr_evt_t;

    typedef enum logic [1:0] {
        H_IDLE  = 2'd0,
        H_BREAK = 2'd1,
        H_LOCK  = 2'd2
    } hunt_e;

    // a pulse width is close to the reference if within a quarter of it
    function automatic logic width_close(input logic [REG_W-1:0] w,
                                         input logic [REG_W-1:0] ref_w);
        logic [REG_W-1:0] diff;
        diff = (w >= ref_w) ? (w - ref_w) : (ref_w - w);
        return diff <= (ref_w >> 2);
    endfunction

endpackage

// File: rtl/lpt_bus_sync.sv
module lpt_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES <= 1) begin : g_one
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b1;
                else     q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
            assign dout = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lpt_break_timer.sv
module lpt_break_timer
    import lpt_pkg::*;
#(
    parameter int TIMER_W  = 16,
    parameter int PRESCALE = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line,      // synchronized bus level
    input  logic [REG_W-1:0]    cmp_val,
    output logic [TIMER_W-1:0]  timer_val,
    output tmr_evt_t            evt
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0]   PRE_LAST = PRE_W'(PRESCALE - 1);
    localparam logic [TIMER_W-1:0] T_MAX    = '1;

    logic               line_q;
    logic               running_q;
    logic [PRE_W-1:0]   pre_q;
    logic [TIMER_W-1:0] timer_q;
    tmr_evt_t           evt_q;

    logic fall, rise, tick;
    logic [REG_W-1:0] next_wide;

    assign fall = line_q & ~line;
    assign rise = ~line_q & line;
    assign tick = running_q && (pre_q == PRE_LAST);
    assign next_wide = REG_W'(timer_q) + REG_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q    <= 1'b1;
            running_q <= 1'b0;
            pre_q     <= '0;
            timer_q   <= '0;
            evt_q     <= '0;
        end else begin
            line_q <= line;
            evt_q  <= '0;
            if (fall) begin
                running_q <= 1'b1;
                timer_q   <= '0;
                pre_q     <= '0;
            end else if (running_q) begin
                if (tick) begin
                    pre_q <= '0;
                    if (timer_q == T_MAX) begin
                        evt_q.overflow <= 1'b1;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                        if (cmp_val != '0 && next_wide == cmp_val)
                            evt_q.match <= 1'b1;
                    end
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
                if (rise) begin
                    running_q <= 1'b0;
                    evt_q.rise <= 1'b1;
                end
            end
        end
    end

    assign timer_val = timer_q;
    assign evt       = evt_q;

    // R2: an idle timer keeps the measured width
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!running_q && !fall) |=> $stable(timer_q));

    // R5: no wrap once at the top
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (timer_q == T_MAX && !fall) |=> (timer_q == T_MAX));

    // R4: a match is a single-cycle event
    p_match_single_r4: assert property (@(posedge clk) disable iff (rst)
        evt_q.match |=> !evt_q.match);

endmodule

// File: rtl/lpt_sync_hunt.sv
module lpt_sync_hunt
    import lpt_pkg::*;
#(
    parameter int SYNC_PULSES = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             pulse_end,
    input  logic [REG_W-1:0] width,
    input  logic [REG_W-1:0] brk_thr,
    output logic             locked
);
    localparam int CNT_W = $clog2(SYNC_PULSES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_PULSES - 1);

    hunt_e            state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [REG_W-1:0] ref_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state_q <= H_IDLE;
            cnt_q   <= '0;
            ref_q   <= '0;
        end else if (pulse_end) begin
            if (width >= brk_thr) begin
                state_q <= H_BREAK;
                cnt_q   <= '0;
            end else if (state_q == H_BREAK) begin
                if (cnt_q == '0) begin
                    ref_q <= width;
                    cnt_q <= CNT_W'(1);
                    if (SYNC_PULSES == 1) state_q <= H_LOCK;
                end else if (width_close(width, ref_q)) begin
                    if (cnt_q == CNT_LAST) state_q <= H_LOCK;
                    else                   cnt_q   <= cnt_q + 1'b1;
                end else begin
                    state_q <= H_IDLE;
                    cnt_q   <= '0;
                end
            end
        end
    end

    assign locked = (state_q == H_LOCK);

    // R8: lock is only entered from the break-seen state
    p_lock_path_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == H_IDLE) |=> (state_q != H_LOCK));

    // R9: a break always leaves lock
    p_break_unlocks_r9: assert property (@(posedge clk) disable iff (rst)
        (pulse_end && width >= brk_thr && !restart) |=> (state_q == H_BREAK));

endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
#(
    parameter logic [REG_W-1:0] BRK_RST = 16'd52
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  tmr_evt_t          evt,
    input  logic [REG_W-1:0]  timer_wide,
    input  logic              locked,
    output logic [REG_W-1:0]  rdata,
    output ctrl_t             ctrl,
    output logic [REG_W-1:0]  cmp_val,
    output logic [REG_W-1:0]  brk_thr,
    output logic              restart,
    output logic              irq
);
    reg_addr_e         a;
    ctrl_t             ctrl_q;
    logic [REG_W-1:0]  cmp_q;
    logic [REG_W-1:0]  brk_q;
    logic [FLAG_N-1:0] flags_q;
    logic [FLAG_N-1:0] set_v, clr_v, dis_v;

    assign a = reg_addr_e'(addr);

    assign set_v[FL_EDGE] = evt.rise & ~ctrl_q.dis_edge;
    assign set_v[FL_CMP]  = evt.match;
    assign set_v[FL_ERR]  = evt.overflow;

    assign clr_v = (wr && a == A_STAT) ? wdata[FLAG_N-1:0] : '0;
    assign dis_v = {ctrl_q.dis_err, ctrl_q.dis_cmp, ctrl_q.dis_edge};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            cmp_q   <= '0;
            brk_q   <= BRK_RST;
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_v) | set_v;
            if (wr) begin
                case (a)
                    A_CTRL:  ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
                    A_TIMER: cmp_q  <= wdata;
                    A_BRK:   brk_q  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (a)
            A_CTRL:  rdata = REG_W'(ctrl_q);
            A_STAT:  rdata = REG_W'({locked, flags_q});
            A_TIMER: rdata = timer_wide;
            default: rdata = brk_q;
        endcase
    end

    assign restart = wr && (a == A_CTRL) && wdata[CTRL_W-1] && !ctrl_q.gate_en;
    assign irq     = |(flags_q & ~dis_v);
    assign ctrl    = ctrl_q;
    assign cmp_val = cmp_q;
    assign brk_thr = brk_q;

    // R3: a disabled edge flag cannot appear
    p_edge_dis_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.dis_edge && !flags_q[FL_EDGE]) |=> !flags_q[FL_EDGE]);

    // R7: write-one-to-clear when no overflow arrives together
    p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
        (wr && a == A_STAT && wdata[FL_ERR] && !evt.overflow) |=> !flags_q[FL_ERR]);

    // R7: a set event is never lost
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        evt.match |=> flags_q[FL_CMP]);

endmodule

// File: rtl/lin_pulse_timer.sv
module lin_pulse_timer
    import lpt_pkg::*;
#(
    parameter int                TIMER_W     = 16,
    parameter int                PRESCALE    = 4,
    parameter int                SYNC_STAGES = 2,
    parameter int                SYNC_PULSES = 5,
    parameter logic [REG_W-1:0]  BRK_RST     = 16'd52
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              bus_rx,
    output logic              bus_tx,
    input  logic              uart_txd,
    output logic              uart_rxd,
    input  logic              test_tx_in,
    output logic              test_rx_out,
    output logic              irq
);
    logic               line_s;
    logic [TIMER_W-1:0] timer_val;
    logic [REG_W-1:0]   timer_wide;
    tmr_evt_t           evt;
    ctrl_t              ctrl;
    logic [REG_W-1:0]   cmp_val, brk_thr;
    logic               restart, locked;

    assign timer_wide = REG_W'(timer_val);

    lpt_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(bus_rx), .dout(line_s)
    );

    lpt_break_timer #(.TIMER_W(TIMER_W), .PRESCALE(PRESCALE)) u_timer (
        .clk(clk), .rst(rst), .line(line_s), .cmp_val(cmp_val),
        .timer_val(timer_val), .evt(evt)
    );

    lpt_sync_hunt #(.SYNC_PULSES(SYNC_PULSES)) u_hunt (
        .clk(clk), .rst(rst), .restart(restart), .pulse_end(evt.rise),
        .width(timer_wide), .brk_thr(brk_thr), .locked(locked)
    );

    lpt_regs #(.BRK_RST(BRK_RST)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .evt(evt), .timer_wide(timer_wide), .locked(locked),
        .rdata(reg_rdata), .ctrl(ctrl), .cmp_val(cmp_val), .brk_thr(brk_thr),
        .restart(restart), .irq(irq)
    );

    // transceiver routing and receive gate
    assign bus_tx      = ctrl.test_mode ? test_tx_in : uart_txd;
    assign test_rx_out = ctrl.test_mode ? bus_rx : 1'b1;
    assign uart_rxd    = (ctrl.gate_en && !locked) ? 1'b1 : bus_rx;

    // R6: no interrupt without a pending flag
    p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (reg_addr != A_STAT || reg_rdata[FLAG_N-1:0] != '0));

endmodule

// File: tb/lin_pulse_timer_test.sv
module lin_pulse_timer_test;
    localparam int P   = 4;
    localparam int TW  = 10;
    localparam int BIT = 8;
    localparam int TMAX = (1 << TW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        bus_rx = 1'b1;
    logic        bus_tx;
    logic        uart_txd = 1'b1;
    logic        uart_rxd;
    logic        test_tx_in = 1'b1;
    logic        test_rx_out;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [15:0] rv;

    always #10 clk = ~clk;   // 50 MHz

    lin_pulse_timer #(.TIMER_W(TW), .PRESCALE(P)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_rx(bus_rx),
        .bus_tx(bus_tx), .uart_txd(uart_txd), .uart_rxd(uart_rxd),
        .test_tx_in(test_tx_in), .test_rx_out(test_rx_out), .irq(irq)
    );

    function automatic int exp_width(int l);
        int w = l / P;
        return (w > TMAX) ? TMAX : w;
    endfunction

    function automatic bit exp_match(int l, int c);
        return (c != 0) && (c <= exp_width(l));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(int l);
        bus_rx = 1'b0;
        repeat (l) @(negedge clk);
        bus_rx = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic send_break;
        bus_rx = 1'b0;
        repeat (13 * BIT) @(negedge clk);
        bus_rx = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    // start bit, 0x55 LSB first, stop bit; stretch stretches low bit b3
    task automatic send_sync(bit stretch);
        logic [9:0] frame;
        frame = {1'b1, 8'h55, 1'b0};
        for (int i = 0; i < 10; i++) begin
            bus_rx = frame[i];
            if (i == 6) begin
                #1;
                chk("R8 gated mid-sync", uart_rxd, 1'b1);
            end
            repeat ((stretch && i == 4) ? 2 * BIT : BIT) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_d;
        seed_d = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, rv); chk("R1 ctrl", rv, 16'h0);
        rd(2'd1, rv); chk("R1 status", rv, 16'h0);
        rd(2'd2, rv); chk("R1 timer", rv, 16'h0);
        rd(2'd3, rv); chk("R1 threshold", rv, 16'd52);
        chk("R1 irq", irq, 1'b0);
        chk("R1 uart_rxd", uart_rxd, 1'b1);

        // R11 control register width
        wr(2'd0, 16'hFFE0); rd(2'd0, rv); chk("R11 upper bits", rv, 16'h0000);
        wr(2'd0, 16'h000A); rd(2'd0, rv); chk("R11 readback", rv, 16'h000A);
        wr(2'd0, 16'h0000);

        // R2 R4 R3 directed
        wr(2'd2, 16'd3);
        pulse(21);
        rd(2'd2, rv); chk("R2 width 21", rv, 16'(exp_width(21)));
        rd(2'd1, rv); chk("R3 R4 flags", rv, 16'h0003);
        chk("R6 irq on", irq, 1'b1);
        // R6 masking
        wr(2'd0, 16'h0003); #1; chk("R6 irq masked", irq, 1'b0);
        rd(2'd1, rv); chk("R6 flags kept", rv[1:0], 2'b11);
        wr(2'd0, 16'h0001); #1; chk("R6 cmp unmasked", irq, 1'b1);
        // R7 clear
        wr(2'd1, 16'h0001); rd(2'd1, rv); chk("R7 clear bit0 only", rv, 16'h0002);
        wr(2'd1, 16'h0000); rd(2'd1, rv); chk("R7 zero write no effect", rv, 16'h0002);
        wr(2'd1, 16'h0007); rd(2'd1, rv); chk("R7 clear all", rv, 16'h0000);

        // R3 edge disabled: timer and compare still work
        wr(2'd0, 16'h0001);
        wr(2'd2, 16'd5);
        pulse(40);
        rd(2'd2, rv); chk("R3 timer while disabled", rv, 16'd10);
        rd(2'd1, rv); chk("R3 no edge flag, cmp set", rv, 16'h0002);
        wr(2'd1, 16'h0007);
        wr(2'd0, 16'h0000);

        // R4 compare beyond width
        wr(2'd2, 16'd11);
        pulse(40);
        rd(2'd1, rv); chk("R4 no match", rv, 16'h0001);
        wr(2'd1, 16'h0007);

        // R2 R4 random widths
        for (int k = 0; k < 20; k++) begin
            int l, c;
            l = 1 + int'($urandom % 200);
            c = 1 + int'($urandom % 60);
            wr(2'd2, 16'(c));
            pulse(l);
            rd(2'd2, rv); chk("R2 random width", rv, 16'(exp_width(l)));
            rd(2'd1, rv); chk("R4 random match", rv[1], exp_match(l, c));
            chk("R3 random edge", rv[0], 1'b1);
            wr(2'd1, 16'h0007);
        end

        // R5 overflow saturation
        wr(2'd2, 16'd0);
        pulse(4200);
        rd(2'd2, rv); chk("R5 saturated", rv, 16'(TMAX));
        rd(2'd1, rv); chk("R5 overflow flag", rv[2], 1'b1);
        wr(2'd0, 16'h0003); #1; chk("R6 overflow irq", irq, 1'b1);
        wr(2'd0, 16'h0007); #1; chk("R6 all masked", irq, 1'b0);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0007);

        // R10 test mode routing
        uart_txd = 1'b1; test_tx_in = 1'b0; #1;
        chk("R10 normal tx", bus_tx, 1'b1);
        chk("R10 normal rx pin", test_rx_out, 1'b1);
        wr(2'd0, 16'h0008); #1;
        chk("R10 test tx", bus_tx, 1'b0);
        chk("R10 test rx high", test_rx_out, 1'b1);
        bus_rx = 1'b0; #1;
        chk("R10 test rx low", test_rx_out, 1'b0);
        repeat (4) @(negedge clk);
        bus_rx = 1'b1;
        repeat (12) @(negedge clk);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0007);

        // R8 gate and sync lock; threshold 13 bits = 26 ticks
        wr(2'd3, 16'd26);
        wr(2'd0, 16'h0010);
        bus_rx = 1'b0; #1;
        chk("R8 gated before break", uart_rxd, 1'b1);
        bus_rx = 1'b1;
        repeat (8) @(negedge clk);
        send_break;
        send_sync(1'b0);
        rd(2'd1, rv); chk("R8 locked", rv[3], 1'b1);
        bus_rx = 1'b0; #1;
        chk("R8 passthrough low", uart_rxd, 1'b0);
        bus_rx = 1'b1; #1;
        chk("R8 passthrough high", uart_rxd, 1'b1);
        repeat (12) @(negedge clk);

        // R9 new break closes gate
        send_break;
        rd(2'd1, rv); chk("R9 relock cleared", rv[3], 1'b0);
        bus_rx = 1'b0; #1;
        chk("R9 gated after break", uart_rxd, 1'b1);
        bus_rx = 1'b1;
        repeat (12) @(negedge clk);

        // R9 stretched sync pulse abandons search
        send_break;
        send_sync(1'b1);
        rd(2'd1, rv); chk("R9 mismatch no lock", rv[3], 1'b0);

        // R8 short pulse below threshold is no break
        pulse(100);
        send_sync(1'b0);
        rd(2'd1, rv); chk("R8 no lock without break", rv[3], 1'b0);

        // R8 restart by gate re-enable after a lock
        send_break;
        send_sync(1'b0);
        rd(2'd1, rv); chk("R8 lock again", rv[3], 1'b1);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h0010);
        rd(2'd1, rv); chk("R8 restart clears lock", rv[3], 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule